// File: doc/BRIEF.md
# GPIO Register Block with Atomic Set/Clear

This block is a general-purpose I/O peripheral behind a single-cycle register port. Each bit of the register word controls one pad line, so the number of lines equals the register width. Software drives lines through an output latch. It can load the whole latch at once through the level register. It can also change chosen bits without a read-modify-write through two mask registers: one forces masked bits to 1, the other forces masked bits to 0. A direction register decides which lines drive their pads. The pad inputs pass through a two-flop synchroniser before they can be read.

Build-time parameters tailor the block to its surroundings. The direction bit can mean "drive" or "listen". Line numbering can be mirrored so that line n sits in bus bit W-1-n. The bus word can be byte-reversed. The set register can read back the latch. An input-only build removes every output. The width must be 8, 16, 32 or 64. Byte reversal with a 64-bit width is refused at elaboration.

The register map is fixed. Address 0 is the level register, 1 the set mask, 2 the clear mask and 3 the direction register. A read requested in one cycle shows on `rd_data` after the next rising edge. `rd_data` then holds until the next read.

Top module: `gpio_regblk`

## Requirements
- R1: After reset the output latch and the direction register are all zeros, `pad_out` is zero, and `rd_data` is zero. With DIR_IS_INPUT=0 every `pad_oe` bit is 0; with DIR_IS_INPUT=1 every bit is 1.
- R2: A write to address 0 loads the whole output latch, and the new value appears on `pad_out` after the next rising edge.
- R3: A write to address 1 sets each latch bit that has a 1 in the mapped mask and leaves the other bits unchanged.
- R4: A write to address 2 clears each latch bit that has a 1 in the mapped mask and leaves the other bits unchanged.
- R5: With DIR_IS_INPUT=0, a direction bit of 1 makes that line drive, so `pad_oe` equals the stored direction word.
- R6: With DIR_IS_INPUT=1, a direction bit of 1 makes that line an input, so `pad_oe` is the inverse of the stored direction word.
- R7: A read of address 0 returns the pad inputs as seen through two synchroniser flops. A line the block drives therefore reads back its own driven value.
- R8: A read of address 1 returns the latch when SET_READBACK=1 and zero when SET_READBACK=0. A read of address 2 always returns zero.
- R9: With MIRROR=1, line n corresponds to bus bit W-1-n, both for writes and for reads.
- R10: With BSWAP=1, the bus word is byte-reversed on the way in and on the way out. Together with MIRROR=1, this makes line i correspond to bus bit 8*(i/8)+7-(i%8).
- R11: With NO_OUT=1, `pad_oe` stays all zeros and `pad_out` stays zero, and writes to addresses 0, 1 and 2 leave the latch unchanged.
- R12: A read of address 3 returns the direction word exactly as it was written. `rd_data` holds its value in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 2 | Register select: 0 level, 1 set mask, 2 clear mask, 3 direction |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | DW | Write word |
| rd_en | input | 1 | Read strobe; data appears after the next edge |
| rd_data | output | DW | Read word, held between reads |
| pad_in | input | DW | Pad input levels |
| pad_out | output | DW | Per-line output value |
| pad_oe | output | DW | Per-line output enable |

## Verification
The embedded properties check several behaviours on every cycle: the masked update rule of the set and clear registers, the full latch load, the frozen latch in the input-only build, the output-enable value that follows each direction write, the two-cycle synchroniser delay, and the hold of `rd_data` between reads. The property for the output-enable value covers both direction polarities. Other behaviours depend on build parameters and on values seen at the bus, so only the directed scenarios can show them. These are the mirrored and byte-reversed lane order, the zero reads of the clear register and of a set register without readback, and the loopback of a driven line through the synchroniser. The scenarios run three builds side by side on a shared bus.

// File: rtl/gpio_regblk_pkg.sv
package gpio_regblk_pkg;
  localparam int unsigned GPIO_AW = 2;

  typedef enum logic [GPIO_AW-1:0] {
    GR_LEVEL = 2'd0,
    GR_SET   = 2'd1,
    GR_CLR   = 2'd2,
    GR_DIR   = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_lane_map.sv
// Maps between bus bit order and line order. The mapping is its own
// inverse, so one instance serves writes and another serves reads.
module gpio_lane_map #(
  parameter int unsigned DW     = 32,
  parameter bit          MIRROR = 1'b0,
  parameter bit          BSWAP  = 1'b0
) (
  input  logic [DW-1:0] src,
  output logic [DW-1:0] dst
);
  localparam int unsigned NB = DW / 8;

  for (genvar k = 0; k < DW; k++) begin : g_lane
    localparam int unsigned P0 = BSWAP  ? ((NB - 1 - k / 8) * 8 + k % 8) : k;
    localparam int unsigned P1 = MIRROR ? (DW - 1 - P0) : P0;
    assign dst[k] = src[P1];
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] sync_q
);
  logic [DW-1:0] stg1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      sync_q <= '0;
    end else begin
      stg1_q <= pad_in;
      sync_q <= stg1_q;
    end
  end

  // cycles since reset, saturating, so the 2-deep look-back stays valid
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_q == $past(pad_in, 2))); // R7
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned DW     = 32,
  parameter bit          NO_OUT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          dir_we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] lat_q,
  output logic [DW-1:0] dir_q
);
  logic [DW-1:0] lat_d;
  logic          lat_en;

  // clear beats set, set beats a full load
  always_comb begin
    lat_d  = lat_q;
    lat_en = 1'b0;
    if (!NO_OUT) begin
      lat_en = ld_we | set_we | clr_we;
      if (clr_we)      lat_d = lat_q & ~d;
      else if (set_we) lat_d = lat_q | d;
      else if (ld_we)  lat_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= d;
  end

  if (!NO_OUT) begin : g_chk_out
    AST_SET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> (((lat_q & $past(d)) == $past(d)) &&
                               ((lat_q & ~$past(d)) == ($past(lat_q) & ~$past(d))))); // R3
    AST_CLR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> (((lat_q & $past(d)) == '0) &&
                  ((lat_q & ~$past(d)) == ($past(lat_q) & ~$past(d))))); // R4
    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_we && !set_we && !clr_we) |=> (lat_q == $past(d))); // R2
  end else begin : g_chk_noout
    AST_NOOUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_we || set_we || clr_we) |=> $stable(lat_q)); // R11
  end
endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
  import gpio_regblk_pkg::*;
#(
  parameter int unsigned DW           = 32,
  parameter bit          DIR_IS_INPUT = 1'b0,
  parameter bit          MIRROR       = 1'b0,
  parameter bit          BSWAP        = 1'b0,
  parameter bit          SET_READBACK = 1'b1,
  parameter bit          NO_OUT       = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GPIO_AW-1:0] addr,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  output logic [DW-1:0]      rd_data,
  input  logic [DW-1:0]      pad_in,
  output logic [DW-1:0]      pad_out,
  output logic [DW-1:0]      pad_oe
);
  if (!(DW == 8 || DW == 16 || DW == 32 || DW == 64)) begin : g_bad_width
    $error("gpio_regblk: DW must be 8, 16, 32 or 64");
  end
  if (BSWAP && DW == 64) begin : g_bad_swap
    $error("gpio_regblk: byte reversal is not available at 64 bits");
  end

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  gpio_reg_e sel;
  logic      ld_we, set_we, clr_we, dir_we;
  assign sel    = gpio_reg_e'(addr);
  assign ld_we  = wr_en && (sel == GR_LEVEL);
  assign set_we = wr_en && (sel == GR_SET);
  assign clr_we = wr_en && (sel == GR_CLR);
  assign dir_we = wr_en && (sel == GR_DIR);

  logic [DW-1:0] wr_lines, lat_q, dir_q, sync_q;

  gpio_lane_map #(.DW(DW), .MIRROR(MIRROR), .BSWAP(BSWAP)) u_wmap (
    .src(wr_data), .dst(wr_lines)
  );

  gpio_out_latch #(.DW(DW), .NO_OUT(NO_OUT)) u_latch (
    .clk(clk), .rst_n(rst_s_n),
    .ld_we(ld_we), .set_we(set_we), .clr_we(clr_we), .dir_we(dir_we),
    .d(wr_lines), .lat_q(lat_q), .dir_q(dir_q)
  );

  gpio_in_sync #(.DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .pad_in(pad_in), .sync_q(sync_q)
  );

  always_comb begin
    pad_out = lat_q;
    if (NO_OUT)            pad_oe = '0;
    else if (DIR_IS_INPUT) pad_oe = ~dir_q;
    else                   pad_oe = dir_q;
  end

  // readback
  logic [DW-1:0] rd_lines, rd_bus, rd_d, rd_q;
  always_comb begin
    unique case (sel)
      GR_LEVEL: rd_lines = sync_q;
      GR_SET:   rd_lines = SET_READBACK ? lat_q : '0;
      GR_CLR:   rd_lines = '0;
      GR_DIR:   rd_lines = dir_q;
      default:  rd_lines = '0;
    endcase
  end

  gpio_lane_map #(.DW(DW), .MIRROR(MIRROR), .BSWAP(BSWAP)) u_rmap (
    .src(rd_lines), .dst(rd_bus)
  );

  always_comb rd_d = rd_en ? rd_bus : rd_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rd_q <= '0;
    else          rd_q <= rd_d;
  end
  assign rd_data = rd_q;

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_s_n)
    dir_we |=> (pad_oe == (NO_OUT ? '0 :
                           (DIR_IS_INPUT ? ~$past(wr_lines) : $past(wr_lines))))); // R5 R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rd_en |=> $stable(rd_data)); // R12
endmodule

// File: tb/gpio_regblk_tb.sv
module gpio_regblk_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr;
  logic        wr_en, rd_en;
  logic [31:0] wr_data;
  logic [31:0] rd_a, out_a, oe_a, ext_a, pin_a;
  logic [15:0] rd_b, out_b, oe_b, ext_b;
  logic [7:0]  rd_c, out_c, oe_c, ext_c;
  int n_chk = 0, n_fail = 0;
  logic [31:0] lat_a;

  always #2 clk = ~clk;  // 250 MHz

  for (genvar i = 0; i < 32; i++) begin : g_loop
    assign pin_a[i] = oe_a[i] ? out_a[i] : ext_a[i];
  end

  gpio_regblk #(.DW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_a), .pad_in(pin_a), .pad_out(out_a), .pad_oe(oe_a));

  gpio_regblk #(.DW(16), .DIR_IS_INPUT(1'b1), .MIRROR(1'b1), .BSWAP(1'b1),
                .SET_READBACK(1'b0)) u_dut_mb (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data[15:0]),
    .rd_en(rd_en), .rd_data(rd_b), .pad_in(ext_b), .pad_out(out_b), .pad_oe(oe_b));

  gpio_regblk #(.DW(8), .NO_OUT(1'b1)) u_dut_ro (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data[7:0]),
    .rd_en(rd_en), .rd_data(rd_c), .pad_in(ext_c), .pad_out(out_c), .pad_oe(oe_c));

  // R9 R10: mirrored and byte-reversed 16-bit lane order
  function automatic logic [15:0] perm16(input logic [15:0] x);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = x[(i / 8) * 8 + 7 - (i % 8)];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(out_a == 0 && oe_a == 0, "R1 A out/oe", {out_a, oe_a}, 0);
    chk(oe_b == 16'hFFFF && out_b == 0, "R1 B oe all ones", {out_b, oe_b}, 64'h0000_FFFF);
    chk(oe_c == 0 && rd_a == 0, "R1 C oe / A rd", {oe_c, rd_a}, 0);
  endtask

  task automatic t_level();
    wr(2'd0, 32'hA5A5_3C3C); lat_a = 32'hA5A5_3C3C;
    chk(out_a == lat_a, "R2 level load", out_a, lat_a);
    chk(out_b == perm16(16'h3C3C), "R9 R10 level lanes", out_b, perm16(16'h3C3C));
    chk(out_c == 0, "R11 level ignored", out_c, 0);
  endtask

  task automatic t_setclr();
    wr(2'd1, 32'h0000_00C3); lat_a = lat_a | 32'h0000_00C3;
    chk(out_a == lat_a, "R3 set mask", out_a, lat_a);
    wr(2'd2, 32'hA000_0001); lat_a = lat_a & ~32'hA000_0001;
    chk(out_a == lat_a, "R4 clear mask", out_a, lat_a);
    chk(out_c == 0, "R11 set/clear ignored", out_c, 0);
    rd(2'd1);
    chk(rd_a == lat_a, "R8 set readback", rd_a, lat_a);
    chk(rd_b == 0, "R8 set readback off", rd_b, 0);
    chk(rd_c == 0, "R11 latch stays zero", rd_c, 0);
    rd(2'd2);
    chk(rd_a == 0, "R8 clear reads zero", rd_a, 0);
  endtask

  task automatic t_dir();
    wr(2'd3, 32'h0000_FF0F);
    chk(oe_a == 32'h0000_FF0F, "R5 output polarity", oe_a, 32'h0000_FF0F);
    chk(oe_b == ~perm16(16'hFF0F), "R6 input polarity", oe_b, ~perm16(16'hFF0F));
    chk(oe_c == 0, "R11 oe held low", oe_c, 0);
    rd(2'd3);
    chk(rd_a == 32'h0000_FF0F, "R12 dir readback", rd_a, 32'h0000_FF0F);
    chk(rd_b == 16'hFF0F, "R10 dir round trip", rd_b, 16'hFF0F);
  endtask

  task automatic t_pads();
    logic [31:0] exp_a;
    logic [31:0] held;
    @(negedge clk); ext_a = 32'h1234_5678; ext_b = 16'h8001;
    repeat (3) @(negedge clk);
    rd(2'd0);
    exp_a = (lat_a & 32'h0000_FF0F) | (32'h1234_5678 & ~32'h0000_FF0F);
    chk(rd_a == exp_a, "R7 pad readback", rd_a, exp_a);
    chk(rd_b == perm16(16'h8001), "R9 R10 pad lanes", rd_b, perm16(16'h8001));
    held = rd_a;
    @(negedge clk); ext_a = 32'hFFFF_0000;
    repeat (4) @(negedge clk);
    chk(rd_a == held, "R12 rd_data holds", rd_a, held);
  endtask

  initial begin
    rst_n = 1'b0; addr = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    ext_a = '0; ext_b = '0; ext_c = 8'h5A; lat_a = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_level();
    t_setclr();
    t_dir();
    t_pads();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule